// File: doc/BRIEF.md
# Block Cipher Control Gatekeeper

This block sits between a register port and a block-cipher core. Software writes a control word, key words, IV words and four input data words; the block decides when the core may start, hands it the operands and takes back a four-word result. It guards against misuse. Configuration writes made while an operation runs are dropped. Control words whose key-length or mode field is not one-hot are refused. A control write or a reset forces software to supply a fresh key and IV. With sideload selected, a key on the sideload port takes the place of the key registers. When the previous result has not been collected, the new result is held back.

The core is reached through a plain start/done handshake. `core_start` is a one-cycle pulse that goes high in the cycle the operands are valid. The core later returns `core_done` for one cycle with `core_result`. Register reads are combinational on `reg_addr` and `reg_re`. Address map: 0 control, 1 trigger, 2 status, 8..15 key words 0..7, 16..19 IV words, 20..23 input data words, 24..27 output data words. Key, IV and input words read as zero.

Top module: `cipher_gate`

## Requirements
- R1: While busy (status bit 0 low), writes to the control word, to any key word and to any IV word are ignored. The control readback and the key that the next operation uses stay as they were.
- R2: Control word fields: bit 0 direction (1 = decrypt), bits 3:1 key length one-hot (bit 1 = 128, bit 2 = 192, bit 3 = 256), bits 6:4 mode one-hot, bit 7 manual start, bit 8 sideload. A write whose length or mode field has zero or several bits set leaves the stored word unchanged and sets the alert flag. It cannot enable a start. The next legal write clears the alert flag.
- R3: In automatic mode an operation starts once the key, the IV and all four input words are present. They may be written in any order and interleaved.
- R4: In manual mode an operation starts only in the cycle of a trigger write with bit 0 set, and only when key, IV and data are present. In automatic mode that bit has no effect.
- R5: After reset or after a legal control write, the key, IV and input records are empty. No operation starts until they are supplied again, and status idle stays set.
- R6: The key is complete only when exactly words 0..3 (128), 0..5 (192) or 0..7 (256) have been written since the last reset, legal control write or input clear. Writing an extra word makes it incomplete.
- R7: A trigger write with bit 1 set, made while idle, overwrites the key, IV and input registers and empties their records. A trigger write with bit 2 set overwrites the output words with filler and clears output_valid.
- R8: After reset the output words read as filler that differs from any earlier result. Control reads 0 and status reads 9.
- R9: When a result arrives while output_valid is still set, it is held and status stall is set. The visible output is unchanged until all four output words have been read or cleared. The held result then appears on the next edge.
- R10: With sideload on, no operation starts until `sl_valid` is high, and the core uses `sl_key`. With sideload off, `sl_valid` and `sl_key` are ignored.
- R11: Status bits: 0 idle, 1 stall, 2 output_valid, 3 input_ready (idle and input words not all present), 4 alert.
- R12: A result accepted from the core appears on the output words on the edge that takes `core_done`, with output_valid set. output_valid clears on the edge after the last unread output word is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| sl_valid | input | 1 | Sideload key valid |
| sl_key | input | NK*DW | Sideload key |
| core_start | output | 1 | Start pulse to the cipher core |
| core_op | output | 1 | Direction, 1 = decrypt |
| core_mode | output | 3 | One-hot mode |
| core_keylen | output | 3 | One-hot key length |
| core_key | output | NK*DW | Key, word 0 in the low bits |
| core_iv | output | NB*DW | IV |
| core_din | output | NB*DW | Input data block |
| core_done | input | 1 | Result valid from the core |
| core_result | input | NB*DW | Result block |

## Verification
In manual mode `core_start` goes high in the same cycle as the qualifying trigger write. In automatic mode it goes high in the cycle after the edge that captures the last missing word or the rising `sl_valid`. Status, control readback and output words change on the edge after the write or read that causes the change. A result lands one edge after the core stub's `done`, which comes a fixed five cycles after the start. A behavioural model in the bench advances on every rising edge. The start pulse and the status word are compared with it one nanosecond after every falling edge, once all inputs have settled. Output words are read only after output_valid has been seen, or a fixed stub latency plus margin after the start.

// File: rtl/cipher_gate.sv
module cipher_gate #(
  parameter int DW = 32,
  parameter int NK = 8,
  parameter int NB = 4,
  parameter logic [DW-1:0] SEED = 'h5EEDC0DE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [4:0]         reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic               sl_valid,
  input  logic [NK*DW-1:0]   sl_key,
  output logic               core_start,
  output logic               core_op,
  output logic [2:0]         core_mode,
  output logic [2:0]         core_keylen,
  output logic [NK*DW-1:0]   core_key,
  output logic [NB*DW-1:0]   core_iv,
  output logic [NB*DW-1:0]   core_din,
  input  logic               core_done,
  input  logic [NB*DW-1:0]   core_result
);

  localparam int CW = 9;

  logic [CW-1:0] cfg_q;
  logic          cfg_ok_q, alert_q, busy_q, ov_q, pv_q, wipe_q;
  logic [NK-1:0] keym_q;
  logic [NB-1:0] ivm_q, dinm_q, rdm_q;
  logic [DW-1:0] key_q  [NK];
  logic [DW-1:0] iv_q   [NB];
  logic [DW-1:0] din_q  [NB];
  logic [DW-1:0] dout_q [NB];
  logic [DW-1:0] pend_q [NB];
  logic [DW-1:0] lfsr_q;

  wire ctrl_wr = reg_we && reg_addr == 5'd0;
  wire trig_wr = reg_we && reg_addr == 5'd1;
  wire key_sel  = reg_addr[4:3] == 2'b01;
  wire iv_sel   = reg_addr[4:2] == 3'b100;
  wire din_sel  = reg_addr[4:2] == 3'b101;
  wire dout_sel = reg_addr[4:2] == 3'b110;

  wire [2:0] wr_klen = reg_wdata[3:1];
  wire [2:0] wr_mode = reg_wdata[6:4];
  wire cfg_legal = ($countones(wr_klen) == 1) && ($countones(wr_mode) == 1);

  wire [NK-1:0] need = cfg_q[1] ? NK'(8'h0F) : (cfg_q[2] ? NK'(8'h3F) : {NK{1'b1}});
  wire key_ok   = cfg_q[8] ? sl_valid : (keym_q == need);
  wire start_rq = trig_wr && reg_wdata[0];
  wire go = !busy_q && !wipe_q && cfg_ok_q && key_ok && (&ivm_q) && (&dinm_q)
            && (cfg_q[7] ? start_rq : 1'b1);

  wire clr_in  = trig_wr && reg_wdata[1] && !busy_q;
  wire clr_out = trig_wr && reg_wdata[2];
  wire dout_rd = reg_re && dout_sel && ov_q;
  wire [NB-1:0] rd_bit = NB'(1) << reg_addr[1:0];
  wire collect = ov_q && ((dout_rd && ((rdm_q | rd_bit) == {NB{1'b1}})) || clr_out);
  wire take    = core_done && busy_q && !pv_q;

  wire [4:0] status = {alert_q, !busy_q && !(&dinm_q), ov_q, pv_q, !busy_q};

  function automatic logic [DW-1:0] fill(input logic [DW-1:0] base, input int i);
    return base ^ DW'(32'h9E3779B9 * (i + 1));
  endfunction

  assign core_start  = go;
  assign core_op     = cfg_q[0];
  assign core_keylen = cfg_q[3:1];
  assign core_mode   = cfg_q[6:4];

  for (genvar g = 0; g < NK; g++) begin : g_key
    assign core_key[g*DW +: DW] = cfg_q[8] ? sl_key[g*DW +: DW] : key_q[g];
  end
  for (genvar g = 0; g < NB; g++) begin : g_blk
    assign core_iv[g*DW +: DW]  = iv_q[g];
    assign core_din[g*DW +: DW] = din_q[g];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 5'd0)      reg_rdata = DW'(cfg_q);
    else if (reg_addr == 5'd2) reg_rdata = DW'(status);
    else if (dout_sel)         reg_rdata = dout_q[reg_addr[1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; cfg_ok_q <= 1'b0; alert_q <= 1'b0; busy_q <= 1'b0;
      ov_q <= 1'b0; pv_q <= 1'b0; wipe_q <= 1'b1; lfsr_q <= SEED;
      keym_q <= '0; ivm_q <= '0; dinm_q <= '0; rdm_q <= '0;
      for (int i = 0; i < NK; i++) key_q[i] <= '0;
      for (int i = 0; i < NB; i++) begin
        iv_q[i] <= '0; din_q[i] <= '0; dout_q[i] <= '0; pend_q[i] <= '0;
      end
    end else begin
      lfsr_q <= {lfsr_q[DW-2:0], lfsr_q[DW-1] ^ lfsr_q[DW-3] ^ lfsr_q[DW-7] ^ lfsr_q[DW-8]};
      if (wipe_q) begin
        wipe_q <= 1'b0;
        for (int i = 0; i < NK; i++) key_q[i] <= fill(lfsr_q, i);
        for (int i = 0; i < NB; i++) begin
          iv_q[i] <= fill(lfsr_q, i + 8); din_q[i] <= fill(lfsr_q, i + 12);
          dout_q[i] <= fill(lfsr_q, i + 16);
        end
      end
      if (ctrl_wr && !busy_q) begin
        if (cfg_legal) begin
          cfg_q <= reg_wdata[CW-1:0]; cfg_ok_q <= 1'b1; alert_q <= 1'b0;
          keym_q <= '0; ivm_q <= '0; dinm_q <= '0;
        end else begin
          alert_q <= 1'b1;
        end
      end
      if (reg_we && !busy_q) begin
        for (int i = 0; i < NK; i++)
          if (key_sel && reg_addr[2:0] == 3'(i)) begin key_q[i] <= reg_wdata; keym_q[i] <= 1'b1; end
        for (int i = 0; i < NB; i++) begin
          if (iv_sel && reg_addr[1:0] == 2'(i)) begin iv_q[i] <= reg_wdata; ivm_q[i] <= 1'b1; end
          if (din_sel && reg_addr[1:0] == 2'(i)) begin din_q[i] <= reg_wdata; dinm_q[i] <= 1'b1; end
        end
      end
      if (clr_in) begin
        keym_q <= '0; ivm_q <= '0; dinm_q <= '0;
        for (int i = 0; i < NK; i++) key_q[i] <= fill(lfsr_q, i + 20);
        for (int i = 0; i < NB; i++) begin
          iv_q[i] <= fill(lfsr_q, i + 28); din_q[i] <= fill(lfsr_q, i + 32);
        end
      end
      if (take) begin
        if (ov_q && !collect) begin
          pv_q <= 1'b1;
          for (int i = 0; i < NB; i++) pend_q[i] <= core_result[i*DW +: DW];
        end else begin
          ov_q <= 1'b1; rdm_q <= '0; busy_q <= 1'b0;
          for (int i = 0; i < NB; i++) dout_q[i] <= core_result[i*DW +: DW];
        end
      end else if (pv_q && collect) begin
        pv_q <= 1'b0; ov_q <= 1'b1; rdm_q <= '0; busy_q <= 1'b0;
        for (int i = 0; i < NB; i++) dout_q[i] <= pend_q[i];
      end else if (collect) begin
        ov_q <= 1'b0; rdm_q <= '0;
        if (clr_out) for (int i = 0; i < NB; i++) dout_q[i] <= fill(lfsr_q, i + 36);
      end else if (clr_out) begin
        for (int i = 0; i < NB; i++) dout_q[i] <= fill(lfsr_q, i + 36);
      end else if (dout_rd) begin
        rdm_q <= rdm_q | rd_bit;
      end
      if (go) begin
        busy_q <= 1'b1; dinm_q <= '0;
      end
    end
  end

  // R1
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(cfg_q) && $stable(keym_q) && $stable(ivm_q)));
  // R2
  legal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> ($countones(core_keylen) == 1 && $countones(core_mode) == 1));
  // R5
  fresh_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> (cfg_ok_q && (&ivm_q) && !busy_q));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && !collect) |=> (pv_q && ov_q && $stable(dout_q[0])));
  // R10
  sideload_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start && cfg_q[8]) |-> sl_valid);
  // R12
  result_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ov_q) |=> (ov_q && !busy_q));

endmodule

// File: tb/test_cipher_gate.sv
module test_cipher_gate;
  localparam int DW = 32, NK = 8, NB = 4, LAT = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [4:0] reg_addr = 5'd2;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic sl_valid = 1'b0;
  logic [NK*DW-1:0] sl_key = '0;
  logic core_start, core_op;
  logic [2:0] core_mode, core_keylen;
  logic [NK*DW-1:0] core_key;
  logic [NB*DW-1:0] core_iv, core_din;
  logic core_done;
  logic [NB*DW-1:0] core_result;

  int checks = 0, fails = 0;
  bit ended = 1'b0;

  cipher_gate #(.DW(DW), .NK(NK), .NB(NB)) i_cipher_gate (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sl_valid(sl_valid), .sl_key(sl_key),
    .core_start(core_start), .core_op(core_op), .core_mode(core_mode),
    .core_keylen(core_keylen), .core_key(core_key), .core_iv(core_iv), .core_din(core_din),
    .core_done(core_done), .core_result(core_result));

  always #2 clk = ~clk;

  // core stub: fixed latency, result = din ^ key ^ iv, inverted for decrypt
  int cnt;
  always @(posedge clk) begin
    if (!rst_n) begin cnt <= 0; core_done <= 1'b0; core_result <= '0; end
    else begin
      core_done <= 1'b0;
      if (core_start) begin
        cnt <= LAT;
        for (int i = 0; i < NB; i++)
          core_result[i*DW +: DW] <= core_din[i*DW +: DW] ^ core_key[i*DW +: DW]
                                   ^ core_iv[i*DW +: DW] ^ {DW{core_op}};
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) core_done <= 1'b1;
      end
    end
  end

  // behavioural reference model
  logic [8:0] m_cfg;
  bit m_cfgok, m_alert, m_busy, m_ov, m_pv;
  logic [7:0] m_keym;
  logic [3:0] m_ivm, m_dinm, m_rdm;

  function automatic bit m_go();
    logic [7:0] nd;
    bit kok;
    nd = m_cfg[1] ? 8'h0F : (m_cfg[2] ? 8'h3F : 8'hFF);
    kok = m_cfg[8] ? sl_valid : (m_keym == nd);
    return !m_busy && m_cfgok && kok && m_ivm == 4'hF && m_dinm == 4'hF &&
           (m_cfg[7] ? (reg_we && reg_addr == 5'd1 && reg_wdata[0]) : 1'b1);
  endfunction

  function automatic logic [4:0] m_status();
    return {m_alert, !m_busy && m_dinm != 4'hF, m_ov, m_pv, !m_busy};
  endfunction

  always @(posedge clk) begin
    bit g, rd, coll, co;
    logic [3:0] b;
    if (!rst_n) begin
      m_cfg = '0; m_cfgok = 0; m_alert = 0; m_busy = 0; m_ov = 0; m_pv = 0;
      m_keym = '0; m_ivm = '0; m_dinm = '0; m_rdm = '0;
    end else begin
      g = m_go();
      co = reg_we && reg_addr == 5'd1 && reg_wdata[2];
      b = 4'b1 << reg_addr[1:0];
      rd = reg_re && reg_addr[4:2] == 3'b110 && m_ov;
      coll = m_ov && ((rd && (m_rdm | b) == 4'hF) || co);
      if (reg_we && !m_busy) begin
        if (reg_addr == 5'd0) begin
          if ($countones(reg_wdata[3:1]) == 1 && $countones(reg_wdata[6:4]) == 1) begin
            m_cfg = reg_wdata[8:0]; m_cfgok = 1; m_alert = 0;
            m_keym = '0; m_ivm = '0; m_dinm = '0;
          end else m_alert = 1;
        end
        if (reg_addr[4:3] == 2'b01) m_keym[reg_addr[2:0]] = 1'b1;
        if (reg_addr[4:2] == 3'b100) m_ivm[reg_addr[1:0]] = 1'b1;
        if (reg_addr[4:2] == 3'b101) m_dinm[reg_addr[1:0]] = 1'b1;
        if (reg_addr == 5'd1 && reg_wdata[1]) begin m_keym = '0; m_ivm = '0; m_dinm = '0; end
      end
      if (core_done && m_busy && !m_pv) begin
        if (m_ov && !coll) m_pv = 1;
        else begin m_ov = 1; m_rdm = '0; m_busy = 0; end
      end else if (m_pv && coll) begin m_pv = 0; m_ov = 1; m_rdm = '0; m_busy = 0; end
      else if (coll) begin m_ov = 0; m_rdm = '0; end
      else if (rd) m_rdm = m_rdm | b;
      if (g) begin m_busy = 1; m_dinm = '0; end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_ne(input logic [31:0] act, input logic [31:0] bad, input string tag);
    checks++;
    if (act === bad) begin
      fails++;
      $display("FAIL %s actual %h expected anything but %h", tag, act, bad);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !ended) begin
      chk({31'b0, core_start}, {31'b0, m_go()}, m_cfg[7] ? "R4 start pulse" : "R3 start pulse");
      if (reg_addr == 5'd2) chk(reg_rdata, {27'b0, m_status()}, "R11 status");
    end
  end

  logic [31:0] bkey [8], biv [4], bdin [4], bsl [8], save [4];

  function automatic logic [31:0] expw(input int i, input bit op, input bit sl);
    return bdin[i] ^ (sl ? bsl[i] : bkey[i]) ^ biv[i] ^ {32{op}};
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 5'd2; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    reg_re = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0; reg_addr = 5'd2;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wkey(input int i, input logic [31:0] v); wr(5'(8 + i), v); bkey[i] = v; endtask
  task automatic wiv(input int i, input logic [31:0] v); wr(5'(16 + i), v); biv[i] = v; endtask
  task automatic wdin(input int i, input logic [31:0] v); wr(5'(20 + i), v); bdin[i] = v; endtask

  task automatic wait_ov();
    logic [31:0] v;
    for (int n = 0; n < 40; n++) begin
      rd(5'd2, v);
      if (v[2]) break;
    end
  endtask

  task automatic read_res(input bit op, input bit sl, input string tag);
    logic [31:0] v;
    for (int i = 0; i < NB; i++) begin
      rd(5'(24 + i), v);
      chk(v, expw(i, op, sl), tag);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11, R5: reset state
    rd(5'd2, v); chk(v, 32'd9, "R11 status after reset");
    rd(5'd0, v); chk(v, 32'd0, "R5 control after reset");
    // R5: start request with nothing configured
    wr(5'd1, 32'h1); idle(2);
    rd(5'd2, v); chk(v, 32'd9, "R5 idle after unconfigured start");
    // R2: illegal control after reset
    wr(5'd0, 32'h16);
    rd(5'd2, v); chk(v, 32'd25, "R2 alert set");
    rd(5'd0, v); chk(v, 32'd0, "R2 control unchanged");
    for (int i = 0; i < 4; i++) wkey(i, 32'hA0000000 + i);
    for (int i = 0; i < 4; i++) wiv(i, 32'hB0000000 + i);
    for (int i = 0; i < 4; i++) wdin(i, 32'hD0000000 + i);
    idle(3);
    rd(5'd2, v); chk(v, 32'd17, "R2 no start on illegal config");
    // R3: legal automatic config, interleaved writes
    wr(5'd0, 32'h12);
    rd(5'd2, v); chk(v, 32'd9, "R2 alert cleared and R5 records emptied");
    wdin(2, 32'hD0000012); wkey(3, 32'hA1000003); wiv(0, 32'hB1000000); wdin(0, 32'hD0000010);
    wkey(1, 32'hA1000001); wiv(3, 32'hB1000003); wkey(0, 32'hA1000000); wdin(1, 32'hD0000011);
    wiv(1, 32'hB1000001); wkey(2, 32'hA1000002); wiv(2, 32'hB1000002); wdin(3, 32'hD0000013);
    wait_ov();
    read_res(0, 0, "R3 interleaved result");
    rd(5'd2, v); chk(v, 32'd9, "R12 output_valid clears after reads");
    // R9: back-to-back with uncollected output
    for (int i = 0; i < 4; i++) wdin(i, 32'hD0000020 + i);
    wait_ov();
    for (int i = 0; i < 4; i++) save[i] = expw(i, 0, 0);
    for (int i = 0; i < 4; i++) wdin(i, 32'hD0000030 + i);
    idle(LAT + 4);
    rd(5'd2, v); chk(v, 32'd6, "R9 stall status");
    for (int i = 0; i < NB; i++) begin
      rd(5'(24 + i), v); chk(v, save[i], "R9 first result held visible");
    end
    read_res(0, 0, "R9 held result released");
    // R1: writes while busy
    for (int i = 0; i < 4; i++) wdin(i, 32'hD0000040 + i);
    idle(1);
    wr(5'd0, 32'h14);
    wr(5'd8, 32'hBAD0BAD0);
    wr(5'd16, 32'hBAD1BAD1);
    wait_ov();
    rd(5'd0, v); chk(v, 32'h12, "R1 control locked while busy");
    read_res(0, 0, "R1 key and IV locked while busy");
    // R4: automatic mode ignores trigger start
    wr(5'd0, 32'h12);
    for (int i = 0; i < 4; i++) wkey(i, 32'hA2000000 + i);
    for (int i = 0; i < 4; i++) wiv(i, 32'hB2000000 + i);
    for (int i = 0; i < 3; i++) wdin(i, 32'hD0000050 + i);
    wr(5'd1, 32'h1); idle(2);
    rd(5'd2, v); chk(v, 32'd9, "R4 trigger start ignored in automatic mode");
    wdin(3, 32'hD0000053);
    wait_ov();
    read_res(0, 0, "R4 automatic result");
    // R6, R7, R4: manual 192-bit decrypt
    wr(5'd0, 32'hA5);
    for (int i = 0; i < 7; i++) wkey(i, 32'hA3000000 + i);
    for (int i = 0; i < 4; i++) wiv(i, 32'hB3000000 + i);
    for (int i = 0; i < 4; i++) wdin(i, 32'hD0000060 + i);
    wr(5'd1, 32'h1); idle(2);
    rd(5'd2, v); chk(v, 32'd1, "R6 extra key word blocks start");
    wr(5'd1, 32'h2);
    rd(5'd2, v); chk(v, 32'd9, "R7 input clear empties records");
    for (int i = 0; i < 6; i++) wkey(i, 32'hA4000000 + i);
    for (int i = 0; i < 4; i++) wiv(i, 32'hB4000000 + i);
    for (int i = 0; i < 4; i++) wdin(i, 32'hD0000070 + i);
    idle(3);
    rd(5'd2, v); chk(v, 32'd1, "R4 manual mode waits for trigger");
    wr(5'd1, 32'h1);
    wait_ov();
    read_res(1, 0, "R4 manual decrypt result");
    // R10: sideload enabled
    wr(5'd0, 32'h148);
    for (int i = 0; i < 4; i++) wiv(i, 32'hB5000000 + i);
    for (int i = 0; i < 4; i++) wdin(i, 32'hD0000080 + i);
    idle(5);
    rd(5'd2, v); chk(v, 32'd1, "R10 waits for sideload valid");
    for (int i = 0; i < 8; i++) begin
      bsl[i] = 32'hC0000000 + i;
      sl_key[i*DW +: DW] = bsl[i];
    end
    sl_valid = 1'b1;
    idle(1);
    sl_valid = 1'b0;
    wait_ov();
    read_res(0, 1, "R10 sideload key used");
    // R10: sideload disabled ignores valid
    wr(5'd0, 32'h12);
    sl_valid = 1'b1;
    for (int i = 0; i < 4; i++) wiv(i, 32'hB6000000 + i);
    for (int i = 0; i < 4; i++) wdin(i, 32'hD0000090 + i);
    idle(5);
    rd(5'd2, v); chk(v, 32'd1, "R10 sideload valid ignored when off");
    sl_valid = 1'b0;
    // R7: output clear
    for (int i = 0; i < 4; i++) wkey(i, 32'hA7000000 + i);
    wait_ov();
    for (int i = 0; i < 4; i++) save[i] = expw(i, 0, 0);
    wr(5'd1, 32'h4);
    rd(5'd2, v); chk(v, 32'd9, "R7 output clear drops output_valid");
    for (int i = 0; i < NB; i++) begin
      rd(5'(24 + i), v); chk_ne(v, save[i], "R7 output overwritten");
    end
    // R8: reset wipes output
    for (int i = 0; i < 4; i++) wdin(i, 32'hD00000A0 + i);
    wait_ov();
    for (int i = 0; i < 4; i++) save[i] = expw(i, 0, 0);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    rd(5'd2, v); chk(v, 32'd9, "R8 status after reset");
    rd(5'd0, v); chk(v, 32'd0, "R8 control after reset");
    for (int i = 0; i < NB; i++) begin
      rd(5'(24 + i), v); chk_ne(v, save[i], "R8 output wiped by reset");
    end
    idle(2);
    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule